// File: doc/BRIEF.md
# Flash Program and Erase Host Controller

This block sits on the host side of a parallel NOR flash bus. It turns one request into a full command transaction on that bus. The request can be a single-word program, an erase of the sector that holds a given address, or an erase of the whole device. For each request the controller writes the unlock and command cycles the device expects. It then reads the target address repeatedly and checks the status flag until the device reports completion or a programmable poll limit runs out.

A program request is not treated as finished when the status flag says so. Once polling succeeds, the controller reads the target word back in normal read mode and compares it with the requested value. A mismatch is reported as an error. This catches an attempt to turn a 0 bit back into a 1, which the device cannot do.

The bus is modelled as one write or one read per clock. Read data returns on the clock after the read strobe. A request is taken when `req_valid` and `req_ready` are both high. The outcome comes back as a one-cycle `done` pulse, with `err` and `err_timeout` valid in that same cycle.

Top module: `flash_pe_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle and no bus strobe is active. A request is taken when `req_valid` and `req_ready` are both high. Requests presented while `req_ready` is low are ignored and cause no bus cycle.
- R2: The operation is selected by `req_op`: 00 is program word, 01 is sector erase, 1x is chip erase. A program issues exactly four writes on consecutive cycles, starting the cycle after acceptance: AAh to 555h, 55h to 2AAh, A0h to 555h, then the request data to the request address.
- R3: A sector erase issues exactly six writes on consecutive cycles, starting the cycle after acceptance: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h to the request address.
- R4: A chip erase issues the same six writes as a sector erase, except that the last one is 10h to address 555h.
- R5: Status polling starts the cycle after the last command write. Every polling read and every verify read uses the request address. The read data is sampled one cycle after `fl_re`.
- R6: A program poll counts as complete when bit 7 of the read data equals bit 7 of the request data.
- R7: An erase poll counts as complete when bit 7 of the read data is 1. An erase ends right after that poll, with no verify read.
- R8: After a complete program poll, one verify read is made at the request address. If the word differs from the request data, the controller reports `err`=1 with `err_timeout`=0. If it matches, it reports success.
- R9: If completion is not seen within max(`cfg_poll_limit`,1) polling reads, the controller stops polling and reports `err`=1 and `err_timeout`=1. The limit is sampled when the request is accepted.
- R10: `done` is high for exactly one cycle per accepted request. `err` and `err_timeout` are valid in that cycle and low otherwise. `req_ready` returns high on the next cycle.
- R11: After the last command write of an operation, no bus write occurs until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr | input | ADDR_W | Target word or sector address |
| req_data | input | DATA_W | Word to program |
| cfg_poll_limit | input | TO_W | Maximum polling reads per operation (0 acts as 1) |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | DATA_W | Flash bus write data |
| fl_rdata | input | DATA_W | Flash bus read data, valid the cycle after `fl_re` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation failed (with `done`) |
| err_timeout | output | 1 | Failure was a poll timeout (with `done`) |

## Verification
The bench drives a flash model that stays busy for a chosen number of polling reads. It runs program, sector-erase and chip-erase requests with both encodings of the chip-erase code, which separates the three command sequences and their final cycles. Busy counts are set one below and exactly at the poll limit, and the limit is also set to zero; these cases separate a completed operation from a timeout at the exact boundary. Program cases that store a 0 where a 1 was asked, once on a bit other than 7 and once on bit 7, separate a verify mismatch from a poll that never completes. A request held high during a busy operation shows that no extra command reaches the bus.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  // Command addresses and bytes of the unlock / command protocol
  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0]  CMD_UNLK_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;

  // Status flag bit position inside a polled word
  localparam int POLL_BIT = 7;

  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    K_PROG = 2'd0,
    K_SECT = 2'd1,
    K_CHIP = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_POLL_RD,
    S_POLL_CHK,
    S_VFY_RD,
    S_VFY_CHK,
    S_FIN
  } state_e;

  function automatic kind_e op_to_kind(input logic [1:0] op);
    if (op[1])      return K_CHIP;
    else if (op[0]) return K_SECT;
    else            return K_PROG;
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  kind_e                    kind,
  input  logic [STEP_W-1:0]        step,
  input  logic [ADDR_W-1:0]        tgt_addr,
  input  logic [DATA_W-1:0]        tgt_data,
  output logic [ADDR_W-1:0]        cyc_addr,
  output logic [DATA_W-1:0]        cyc_data,
  output logic                     cyc_last
);

  localparam logic [ADDR_W-1:0] A_UA = ADDR_W'(UNLK_ADDR_A);
  localparam logic [ADDR_W-1:0] A_UB = ADDR_W'(UNLK_ADDR_B);

  always_comb begin
    cyc_addr = A_UA;
    cyc_data = DATA_W'(CMD_UNLK_A);
    cyc_last = 1'b0;
    if (kind == K_PROG) begin
      case (step)
        3'd0: begin cyc_addr = A_UA; cyc_data = DATA_W'(CMD_UNLK_A); end
        3'd1: begin cyc_addr = A_UB; cyc_data = DATA_W'(CMD_UNLK_B); end
        3'd2: begin cyc_addr = A_UA; cyc_data = DATA_W'(CMD_PROG);   end
        default: begin
          cyc_addr = tgt_addr;
          cyc_data = tgt_data;
          cyc_last = 1'b1;
        end
      endcase
    end else begin
      case (step)
        3'd0: begin cyc_addr = A_UA; cyc_data = DATA_W'(CMD_UNLK_A); end
        3'd1: begin cyc_addr = A_UB; cyc_data = DATA_W'(CMD_UNLK_B); end
        3'd2: begin cyc_addr = A_UA; cyc_data = DATA_W'(CMD_ERASE);  end
        3'd3: begin cyc_addr = A_UA; cyc_data = DATA_W'(CMD_UNLK_A); end
        3'd4: begin cyc_addr = A_UB; cyc_data = DATA_W'(CMD_UNLK_B); end
        default: begin
          cyc_last = 1'b1;
          if (kind == K_CHIP) begin
            cyc_addr = A_UA;
            cyc_data = DATA_W'(CMD_CHIP);
          end else begin
            cyc_addr = tgt_addr;
            cyc_data = DATA_W'(CMD_SECTOR);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [TO_W-1:0] limit,
  input  logic            tick,
  output logic            last_try
);

  logic [TO_W-1:0] lim_q;
  logic [TO_W-1:0] cnt_q;
  logic [TO_W:0]   tries;

  // tries = number of the polling read being judged now (1-based)
  assign tries    = {1'b0, cnt_q} + {{TO_W{1'b0}}, 1'b1};
  assign last_try = (tries >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (tick && !last_try) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval
  import flash_pe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  kind_e              kind,
  input  logic [DATA_W-1:0]  rdata,
  input  logic [DATA_W-1:0]  wdata,
  output logic               poll_done,
  output logic               word_match
);

  always_comb begin
    if (kind == K_PROG) poll_done = (rdata[POLL_BIT] == wdata[POLL_BIT]);
    else                poll_done = rdata[POLL_BIT];
    word_match = (rdata == wdata);
  end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TO_W-1:0]   cfg_poll_limit,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              done,
  output logic              err,
  output logic              err_timeout
);

  state_e              state_q;
  kind_e               kind_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [STEP_W-1:0]   step_q;
  logic                done_q, err_q, to_q;

  logic [ADDR_W-1:0]   seq_addr;
  logic [DATA_W-1:0]   seq_data;
  logic                seq_last;
  logic                poll_done, word_match, last_try;
  logic                accept, tmr_tick;

  assign accept   = req_valid && (state_q == S_IDLE);
  assign tmr_tick = (state_q == S_POLL_CHK) && !poll_done;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .kind     (kind_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (seq_addr),
    .cyc_data (seq_data),
    .cyc_last (seq_last)
  );

  flash_poll_timer #(.TO_W(TO_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .limit    (cfg_poll_limit),
    .tick     (tmr_tick),
    .last_try (last_try)
  );

  flash_status_eval #(.DATA_W(DATA_W)) u_eval (
    .kind       (kind_q),
    .rdata      (fl_rdata),
    .wdata      (data_q),
    .poll_done  (poll_done),
    .word_match (word_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      kind_q  <= K_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      to_q   <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            kind_q  <= op_to_kind(req_op);
            addr_q  <= req_addr;
            data_q  <= req_data;
            step_q  <= '0;
            state_q <= S_CMD;
          end
        end
        S_CMD: begin
          if (seq_last) state_q <= S_POLL_RD;
          else          step_q  <= step_q + 1'b1;
        end
        S_POLL_RD: state_q <= S_POLL_CHK;
        S_POLL_CHK: begin
          if (poll_done) begin
            if (kind_q == K_PROG) begin
              state_q <= S_VFY_RD;
            end else begin
              state_q <= S_FIN;
              done_q  <= 1'b1;
            end
          end else if (last_try) begin
            state_q <= S_FIN;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            to_q    <= 1'b1;
          end else begin
            state_q <= S_POLL_RD;
          end
        end
        S_VFY_RD: state_q <= S_VFY_CHK;
        S_VFY_CHK: begin
          state_q <= S_FIN;
          done_q  <= 1'b1;
          err_q   <= !word_match;
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready   = (state_q == S_IDLE);
    fl_we       = (state_q == S_CMD);
    fl_re       = (state_q == S_POLL_RD) || (state_q == S_VFY_RD);
    fl_addr     = (state_q == S_CMD) ? seq_addr : addr_q;
    fl_wdata    = (state_q == S_CMD) ? seq_data : '0;
    done        = done_q;
    err         = err_q;
    err_timeout = to_q;
  end

endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              fl_we,
  input logic              fl_re,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              done,
  input logic              err,
  input logic              err_timeout
);

  logic [ADDR_W-1:0] tgt_q;
  logic [2:0]        nwr_q, need_q;
  logic              active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q    <= '0;
      nwr_q    <= '0;
      need_q   <= '0;
      active_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        tgt_q    <= req_addr;
        nwr_q    <= '0;
        need_q   <= (req_op == 2'b00) ? 3'd4 : 3'd6;
        active_q <= 1'b1;
      end else begin
        if (fl_we) nwr_q <= nwr_q + 3'd1;
        if (done)  active_q <= 1'b0;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!fl_we && !fl_re));

  a_r2_first_unlock: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (fl_we && fl_addr == ADDR_W'(UNLK_ADDR_A)));

  a_r5_poll_at_target: assert property (@(posedge clk) disable iff (rst)
    fl_re |-> (active_q && fl_addr == tgt_q));

  a_r11_no_write_when_busy: assert property (@(posedge clk) disable iff (rst)
    fl_we |-> (active_q && nwr_q < need_q));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));

  a_r10_flags_with_done: assert property (@(posedge clk) disable iff (rst)
    (err || err_timeout) |-> done);

  a_r9_timeout_is_err: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> err);

endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .fl_we       (fl_we),
  .fl_re       (fl_re),
  .fl_addr     (fl_addr),
  .done        (done),
  .err         (err),
  .err_timeout (err_timeout)
);

// File: tb/flash_pe_ctrl_tb.sv
module flash_pe_ctrl_tb;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] cfg_poll_limit = '0;
  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata;
  logic          done, err, err_timeout;

  always #4 clk = ~clk;

  flash_pe_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TO_W(TW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .cfg_poll_limit(cfg_poll_limit), .fl_we(fl_we), .fl_re(fl_re),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .done(done), .err(err), .err_timeout(err_timeout)
  );

  // ---------------- flash device model ----------------
  logic [DW-1:0] mem [16];
  logic          clr_log = 1'b0;
  logic          ld_en = 1'b0;
  logic [3:0]    ld_idx = '0;
  logic [DW-1:0] ld_val = '0;
  int            cfg_busy = 0;
  int            exp_nwr = 4;
  bit            cur_prog = 1'b1;
  logic [DW-1:0] cur_data = '0;
  logic [AW-1:0] cur_tgt = '0;

  int            cyc = 0;
  int            busy_left = 0;
  int            wr_n = 0, rd_n = 0;
  int            acc_cyc = 0, first_wr = 0, last_wr = 0, first_rd = 0;
  bit            bad_raddr = 1'b0;
  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];
  logic [DW-1:0] rdata_r = '0;

  assign fl_rdata = rdata_r;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ld_en) mem[ld_idx] <= ld_val;
    if (clr_log) begin
      wr_n <= 0; rd_n <= 0; bad_raddr <= 1'b0; busy_left <= 0;
    end else begin
      if (req_valid && req_ready) acc_cyc <= cyc;
      if (fl_we) begin
        if (wr_n < 8) begin
          wa[wr_n] <= fl_addr;
          wd[wr_n] <= fl_wdata;
        end
        if (wr_n == 0) first_wr <= cyc;
        last_wr <= cyc;
        wr_n <= wr_n + 1;
        if (wr_n + 1 == exp_nwr) begin
          busy_left <= cfg_busy;
          if (cur_prog) mem[fl_addr[3:0]] <= mem[fl_addr[3:0]] & fl_wdata;
          else for (int k = 0; k < 16; k++) mem[k] <= 16'hFFFF;
        end
      end
      if (fl_re) begin
        if (rd_n == 0) first_rd <= cyc;
        rd_n <= rd_n + 1;
        if (fl_addr != cur_tgt) bad_raddr <= 1'b1;
        if (busy_left > 0) begin
          busy_left <= busy_left - 1;
          rdata_r <= cur_prog ? (~cur_data & 16'h0080) : 16'h0040;
        end else begin
          rdata_r <= mem[fl_addr[3:0]];
        end
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW+DW-1:0] exp_wr(input logic [1:0] op, input int i,
      input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] u1 = AW'(12'h555);
    logic [AW-1:0] u2 = AW'(12'h2AA);
    if (op == 2'b00) begin
      case (i)
        0: return {u1, 16'h00AA};
        1: return {u2, 16'h0055};
        2: return {u1, 16'h00A0};
        default: return {a, d};
      endcase
    end else begin
      case (i)
        0: return {u1, 16'h00AA};
        1: return {u2, 16'h0055};
        2: return {u1, 16'h0080};
        3: return {u1, 16'h00AA};
        4: return {u2, 16'h0055};
        default: return op[1] ? {u1, 16'h0010} : {a, 16'h0030};
      endcase
    end
  endfunction

  // op, addr, data, init, busy polls, limit, exp_err, exp_to, exp reads
  localparam int NV = 11;
  localparam logic [89:0] VEC [NV] = '{
    {2'd0, 22'h000123, 16'h1234, 16'hFFFF, 8'd3,   16'd10, 1'b0, 1'b0, 8'd5},
    {2'd0, 22'h3FFFF0, 16'hA5C3, 16'hFFFF, 8'd0,   16'd5,  1'b0, 1'b0, 8'd2},
    {2'd1, 22'h012345, 16'h0000, 16'hFFFF, 8'd5,   16'd20, 1'b0, 1'b0, 8'd6},
    {2'd2, 22'h000000, 16'h0000, 16'hFFFF, 8'd2,   16'd4,  1'b0, 1'b0, 8'd3},
    {2'd0, 22'h000004, 16'hFF0F, 16'h00F0, 8'd1,   16'd8,  1'b1, 1'b0, 8'd3},
    {2'd0, 22'h000005, 16'h1111, 16'hFFFF, 8'd9,   16'd4,  1'b1, 1'b1, 8'd4},
    {2'd1, 22'h000100, 16'h0000, 16'hFFFF, 8'd200, 16'd0,  1'b1, 1'b1, 8'd1},
    {2'd0, 22'h000007, 16'h0080, 16'h0000, 8'd0,   16'd6,  1'b1, 1'b1, 8'd6},
    {2'd0, 22'h000008, 16'h5A5A, 16'hFFFF, 8'd3,   16'd4,  1'b0, 1'b0, 8'd5},
    {2'd0, 22'h000009, 16'h5A5A, 16'hFFFF, 8'd4,   16'd4,  1'b1, 1'b1, 8'd4},
    {2'd3, 22'h000222, 16'h0000, 16'hFFFF, 8'd1,   16'd3,  1'b0, 1'b0, 8'd2}
  };

  task automatic start_op(input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] d, input logic [DW-1:0] init, input int busy,
      input logic [TW-1:0] lim);
    @(negedge clk);
    clr_log = 1'b1; ld_en = 1'b1; ld_idx = a[3:0]; ld_val = init;
    cfg_busy = busy; exp_nwr = (op == 2'b00) ? 4 : 6;
    cur_prog = (op == 2'b00); cur_data = d; cur_tgt = a;
    cfg_poll_limit = lim;
    @(negedge clk);
    clr_log = 1'b0; ld_en = 1'b0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    ok = done;
    chk(ok, "R10", "done seen", {63'd0, done}, 64'd1);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ok;
    for (int k = 0; k < 16; k++) mem[k] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready === 1'b1, "R1", "ready in reset", {63'd0, req_ready}, 64'd1);
    chk(fl_we === 1'b0 && fl_re === 1'b0, "R1", "strobes in reset", {62'd0, fl_we, fl_re}, 64'd0);
    chk(done === 1'b0, "R10", "done in reset", {63'd0, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]    op   = VEC[v][89:88];
      logic [AW-1:0] a    = VEC[v][87:66];
      logic [DW-1:0] d    = VEC[v][65:50];
      logic [DW-1:0] ini  = VEC[v][49:34];
      int            bz   = int'(VEC[v][33:26]);
      logic [TW-1:0] lim  = VEC[v][25:10];
      logic          xerr = VEC[v][9];
      logic          xto  = VEC[v][8];
      int            xrd  = int'(VEC[v][7:0]);
      int            nw   = (op == 2'b00) ? 4 : 6;
      string         rq   = (op == 2'b00) ? "R2" : (op[1] ? "R4" : "R3");
      start_op(op, a, d, ini, bz, lim);
      chk(req_ready === 1'b0, "R1", "ready low while busy", {63'd0, req_ready}, 64'd0);
      wait_done(ok);
      if (ok) begin
        chk(err === xerr, xto ? "R9" : (op == 2'b00 ? "R8" : "R7"), "err", {63'd0, err}, {63'd0, xerr});
        chk(err_timeout === xto, "R9", "err_timeout", {63'd0, err_timeout}, {63'd0, xto});
        chk(rd_n == xrd, (op == 2'b00) ? "R6" : "R7", "read count", rd_n, xrd);
        chk(wr_n == nw, rq, "write count", wr_n, nw);
        for (int i = 0; i < nw; i++)
          chk({wa[i], wd[i]} == exp_wr(op, i, a, d), rq, "write cycle",
              {wa[i], wd[i]}, exp_wr(op, i, a, d));
        chk(first_wr == acc_cyc + 1 && last_wr == first_wr + nw - 1, rq,
            "write cycles consecutive after accept", last_wr - acc_cyc, nw);
        chk(first_rd == last_wr + 1, "R5", "first poll cycle", first_rd - last_wr, 1);
        chk(!bad_raddr, "R5", "read address", {63'd0, bad_raddr}, 64'd0);
      end
      @(negedge clk);
      chk(done === 1'b0 && req_ready === 1'b1, "R10", "single done, ready back",
          {62'd0, done, req_ready}, 64'd1);
      chk(err === 1'b0 && err_timeout === 1'b0, "R10", "flags low after done",
          {62'd0, err, err_timeout}, 64'd0);
    end

    // directed: requests while busy are ignored (R1, R11)
    start_op(2'b00, 22'h00000A, 16'h0F0F, 16'hFFFF, 6, 16'd20);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_addr = 22'h000ABC;
    wait_done(ok);
    req_valid = 1'b0;
    chk(err === 1'b0, "R8", "busy-ignore program result", {63'd0, err}, 64'd0);
    chk(wr_n == 4, "R11", "no extra write while busy", wr_n, 4);
    repeat (8) @(negedge clk);
    chk(wr_n == 4 && rd_n == 8, "R1", "held request not taken", {wr_n[31:0], rd_n[31:0]}, {32'd4, 32'd8});
    chk(req_ready === 1'b1 && fl_we === 1'b0, "R1", "idle after ignore", {62'd0, req_ready, fl_we}, 64'd2);

    // directed: limit sampled at accept (R9)
    start_op(2'b01, 22'h000011, 16'h0000, 16'hFFFF, 3, 16'd2);
    cfg_poll_limit = 16'd50;
    wait_done(ok);
    chk(err_timeout === 1'b1 && rd_n == 2, "R9", "limit sampled at accept",
        {rd_n[31:0], 31'd0, err_timeout}, {32'd2, 32'd1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule